// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Capture

This block turns the synchronized pin levels of a GPIO port into interrupt events and combines them into one interrupt request for a parent controller. Each pin has three configuration bits. One selects level or edge sensing. One selects positive or negative polarity. One forces detection on both edges. Events are held in a capture register, which software acknowledges by writing ones. An enable mask gates which pending pins may raise the combined request.

Software reaches the block over a simple 32-bit register bus with select, write strobe, address and write data. Read data is registered and appears one cycle after the read. The enable mask is changed only through two alias addresses: one sets bits, the other clears them. Reading either alias returns the current mask. Bit i of every register belongs to pin i.

Top module: `pin_irq_capture`

## Requirements
- R1: After reset, the polarity, both-edge, sense-mode, enable and capture registers all read 0, and `irq_out` is 0.
- R2: Polarity (offset 0x18), both-edge (0x1C) and sense-mode (0x2C) are plain read/write registers. Read data appears on `bus_rdata` on the cycle after the read strobe. Unmapped offsets read 0.
- R3: Writing a mask to 0x30 sets those enable bits and writing a mask to 0x34 clears them; other bits are unchanged, and both offsets read back the enable mask.
- R4: In edge mode (sense bit 0) with polarity bit 0 and both-edge bit 0, a rising pin sets its capture bit (offset 0x20) on the clock edge that first samples the new level; a falling pin sets nothing.
- R5: In edge mode with polarity bit 1, a falling pin sets its capture bit and a rising pin does not.
- R6: A both-edge bit of 1 makes either transition set the capture bit, whatever the polarity bit.
- R7: An edge-mode capture bit stays set until a 1 is written to it at offset 0x20; writing 0 leaves it set.
- R8: In level mode (sense bit 1), the capture bit follows the active level one cycle later: high when polarity is 0, low when polarity is 1. A clear written while the level is still active has no lasting effect.
- R9: `irq_out` is a register holding the OR over all pins of (capture AND enable) from the previous cycle. A pending pin whose enable bit is 0 does not raise it.
- R10: When a new edge and a clear of the same capture bit arrive in the same cycle, the bit ends up set.
- R11: A write to enable-clear followed by a write of the same bit to the capture register leaves that pin neither pending nor raising `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, valid with `bus_sel` |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pin_lvl | input | NPINS (32) | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt request to the parent controller |

## Verification
Some properties are checked on every cycle. `irq_out` must follow any enabled pending pin and must fall once no pin is enabled. Set and clear writes must take effect on the enable mask. An edge-mode capture bit may drop only under a write of 1. A level-mode capture bit must equal the active level of the previous cycle. Other behaviours show up only in the bench's scenarios: which transition each polarity and both-edge setting accepts, the outcome of an edge colliding with its own clear, the mask-then-acknowledge order, and read-back through the register map. A random phase compares the interrupt line and every read against a cycle model kept in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register byte offsets; software depends on these positions.
  localparam int OFF_POL   = 'h18;
  localparam int OFF_BOTH  = 'h1C;
  localparam int OFF_CAP   = 'h20;
  localparam int OFF_MODE  = 'h2C;
  localparam int OFF_ENSET = 'h30;
  localparam int OFF_ENCLR = 'h34;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  w1c
);
  logic             wr_en;
  logic [NPINS-1:0] wmask;

  assign wr_en = bus_sel & bus_wr;
  assign wmask = bus_wdata[NPINS-1:0];
  assign w1c   = (wr_en && bus_addr == ADDR_W'(OFF_CAP)) ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= '0;
      both_q <= '0;
      mode_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        ADDR_W'(OFF_POL):   pol_q  <= wmask;
        ADDR_W'(OFF_BOTH):  both_q <= wmask;
        ADDR_W'(OFF_MODE):  mode_q <= wmask;
        ADDR_W'(OFF_ENSET): en_q   <= en_q | wmask;
        ADDR_W'(OFF_ENCLR): en_q   <= en_q & ~wmask;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqc_sense.sv
module irqc_sense #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [NPINS-1:0] pol_q,
  input  logic [NPINS-1:0] both_q,
  output logic [NPINS-1:0] evt,
  output logic [NPINS-1:0] act
);
  logic [NPINS-1:0] prev_q;

  // Tracks the pins in every cycle, reset included, so that a pin already
  // high when reset ends is not taken for a rising edge.
  always_ff @(posedge clk) prev_q <= pin_lvl;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall;
    assign rise   = pin_lvl[i] & ~prev_q[i];
    assign fall   = ~pin_lvl[i] & prev_q[i];
    assign evt[i] = both_q[i] ? (rise | fall) : (pol_q[i] ? fall : rise);
    assign act[i] = pin_lvl[i] ^ pol_q[i];
  end
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] evt,
  input  logic [NPINS-1:0] act,
  input  logic [NPINS-1:0] mode_q,
  input  logic [NPINS-1:0] en_q,
  input  logic [NPINS-1:0] w1c,
  output logic [NPINS-1:0] cap_q,
  output logic             irq_q
);
  logic [NPINS-1:0] cap_n;

  // Level pins mirror the active level; edge pins are sticky, and a new
  // event outranks a clear in the same cycle.
  assign cap_n = (mode_q & act) | (~mode_q & ((cap_q & ~w1c) | evt));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cap_q <= cap_n;
      irq_q <= |(cap_q & en_q);
    end
  end
endmodule

// File: rtl/pin_irq_capture.sv
module pin_irq_capture
  import irqc_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_lvl,
  output logic              irq_out
);
  logic [NPINS-1:0]  pol_q, both_q, mode_q, en_q, w1c;
  logic [NPINS-1:0]  evt, act, cap_q;
  logic [DATA_W-1:0] rd_mux;

  irqc_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pol_q(pol_q), .both_q(both_q), .mode_q(mode_q), .en_q(en_q), .w1c(w1c)
  );

  irqc_sense #(.NPINS(NPINS)) u_sense (
    .clk(clk), .pin_lvl(pin_lvl), .pol_q(pol_q), .both_q(both_q),
    .evt(evt), .act(act)
  );

  irqc_capture #(.NPINS(NPINS)) u_cap (
    .clk(clk), .rst(rst), .evt(evt), .act(act), .mode_q(mode_q),
    .en_q(en_q), .w1c(w1c), .cap_q(cap_q), .irq_q(irq_out)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_POL):   rd_mux = DATA_W'(pol_q);
      ADDR_W'(OFF_BOTH):  rd_mux = DATA_W'(both_q);
      ADDR_W'(OFF_CAP):   rd_mux = DATA_W'(cap_q);
      ADDR_W'(OFF_MODE):  rd_mux = DATA_W'(mode_q);
      ADDR_W'(OFF_ENSET): rd_mux = DATA_W'(en_q);
      ADDR_W'(OFF_ENCLR): rd_mux = DATA_W'(en_q);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irqc_check.sv
module irqc_check
  import irqc_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPINS-1:0]  pin_lvl,
  input logic              irq_out,
  input logic [NPINS-1:0]  cap_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  pol_q
);
  logic [NPINS-1:0] ack_mask;
  logic             set_wr, clr_wr;

  assign ack_mask = (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CAP)) ? bus_wdata[NPINS-1:0] : '0;
  assign set_wr   = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_ENSET);
  assign clr_wr   = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_ENCLR);

  p_irq_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_out);

  p_enable_set_r3: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((en_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  p_enable_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((en_q & $past(bus_wdata[NPINS-1:0])) == '0));

  p_edge_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(cap_q & ~mode_q & ~ack_mask) & ~cap_q) == '0));

  p_level_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(mode_q)) & (cap_q ^ $past(pin_lvl ^ pol_q))) == '0));

  p_irq_raised_r9: assert property (@(posedge clk) disable iff (rst)
    (|(cap_q & en_q)) |=> irq_out);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_out);
endmodule

bind pin_irq_capture irqc_check #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_lvl(pin_lvl), .irq_out(irq_out), .cap_q(cap_q),
  .en_q(en_q), .mode_q(mode_q), .pol_q(pol_q)
);

// File: tb/pin_irq_capture_test.sv
module pin_irq_capture_test;
  localparam int NP = 32;
  localparam logic [7:0] A_POL = 8'h18, A_BOTH = 8'h1C, A_CAP = 8'h20,
                         A_MODE = 8'h2C, A_SET = 8'h30, A_CLR = 8'h34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pins = '0;
  logic        irq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  pin_irq_capture uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lvl(pins), .irq_out(irq_out)
  );

  // ---------------- cycle model built from the requirements ----------------
  logic [NP-1:0] m_pol, m_both, m_mode, m_en, m_cap, m_prev;
  logic          m_irq;

  function automatic logic [NP-1:0] m_events(input logic [NP-1:0] p, pv, pl, bo);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) begin
      if (bo[i])      r[i] = p[i] != pv[i];          // R6
      else if (pl[i]) r[i] = !p[i] && pv[i];         // R5
      else            r[i] = p[i] && !pv[i];         // R4
    end
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      A_POL:         return m_pol;
      A_BOTH:        return m_both;
      A_CAP:         return m_cap;
      A_MODE:        return m_mode;
      A_SET, A_CLR:  return m_en;
      default:       return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [NP-1:0] ack, ev;
    m_prev <= pins;
    if (rst) begin
      m_pol <= '0; m_both <= '0; m_mode <= '0; m_en <= '0; m_cap <= '0; m_irq <= 1'b0;
    end else begin
      ack = (bus_sel && bus_wr && bus_addr == A_CAP) ? bus_wdata : '0;
      ev  = m_events(pins, m_prev, m_pol, m_both);
      for (int i = 0; i < NP; i++)
        m_cap[i] <= m_mode[i] ? (pins[i] ^ m_pol[i]) : ((m_cap[i] && !ack[i]) || ev[i]);
      m_irq <= |(m_cap & m_en);
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          A_POL:  m_pol  <= bus_wdata;
          A_BOTH: m_both <= bus_wdata;
          A_MODE: m_mode <= bus_wdata;
          A_SET:  m_en   <= m_en | bus_wdata;
          A_CLR:  m_en   <= m_en & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic pend_rd;
    logic [31:0] pend_exp;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd_chk("R1 pol",  A_POL,  0);
    rd_chk("R1 both", A_BOTH, 0);
    rd_chk("R1 cap",  A_CAP,  0);
    rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 en",   A_SET,  0);
    chk("R1 irq", 32'(irq_out), 0);

    // R2 config readback and unmapped offset
    wr(A_POL, 32'hA5A5_0F0F); wr(A_BOTH, 32'h1234_5678); wr(A_MODE, 32'hC0DE_0001);
    rd_chk("R2 pol",  A_POL,  32'hA5A5_0F0F);
    rd_chk("R2 both", A_BOTH, 32'h1234_5678);
    rd_chk("R2 mode", A_MODE, 32'hC0DE_0001);
    rd_chk("R2 unmapped", 8'h04, 0);
    wr(A_MODE, 0); wr(A_POL, 0); wr(A_BOTH, 0); wr(A_CAP, 32'hFFFF_FFFF);
    rd_chk("R2 cap cleaned", A_CAP, 0);

    // R3 enable aliases
    wr(A_SET, 32'hFF); wr(A_CLR, 32'h0F);
    rd_chk("R3 set alias", A_SET, 32'hF0);
    rd_chk("R3 clr alias", A_CLR, 32'hF0);
    wr(A_CLR, 32'hFFFF_FFFF);

    // R4 rising edge, R7 sticky and write-0 ignored
    set_pins(32'h1);
    rd_chk("R4 rise sets", A_CAP, 32'h1);
    wr(A_CAP, 0);
    rd_chk("R7 write0 ignored", A_CAP, 32'h1);
    wr(A_CAP, 32'h1);
    rd_chk("R7 w1c clears", A_CAP, 0);
    set_pins(32'h0);
    rd_chk("R4 fall ignored", A_CAP, 0);

    // R5 negative polarity
    wr(A_POL, 32'h2);
    set_pins(32'h2);
    rd_chk("R5 rise ignored", A_CAP, 0);
    set_pins(32'h0);
    rd_chk("R5 fall sets", A_CAP, 32'h2);
    wr(A_CAP, 32'h2);

    // R6 both edges override polarity
    wr(A_POL, 32'h6); wr(A_BOTH, 32'h4);
    set_pins(32'h4);
    rd_chk("R6 rise sets", A_CAP, 32'h4);
    wr(A_CAP, 32'h4);
    set_pins(32'h0);
    rd_chk("R6 fall sets", A_CAP, 32'h4);
    wr(A_CAP, 32'h4);
    rd_chk("R6 cleared", A_CAP, 0);

    // R8 level mode
    wr(A_POL, 32'h6); wr(A_MODE, 32'h8);
    rd_chk("R8 inactive low", A_CAP, 0);
    set_pins(32'h8);
    rd_chk("R8 high active", A_CAP, 32'h8);
    wr(A_CAP, 32'h8);
    rd_chk("R8 clear no effect", A_CAP, 32'h8);
    set_pins(32'h0);
    rd_chk("R8 follows low", A_CAP, 0);
    wr(A_POL, 32'hE);
    rd_chk("R8 neg pol low active", A_CAP, 32'h8);
    set_pins(32'h8);
    rd_chk("R8 neg pol high inactive", A_CAP, 0);
    wr(A_MODE, 0); wr(A_POL, 0); wr(A_BOTH, 0);
    set_pins(32'h0);

    // R9 enable gating and irq latency
    set_pins(32'h1);
    @(negedge clk);
    chk("R9 disabled no irq", 32'(irq_out), 0);
    wr(A_SET, 32'h1);
    @(negedge clk);
    chk("R9 enabled irq", 32'(irq_out), 1);
    wr(A_CLR, 32'h1);
    @(negedge clk);
    chk("R9 masked irq", 32'(irq_out), 0);

    // R10 edge and clear together
    set_pins(32'h0);
    @(negedge clk); pins = 32'h1; bus_sel = 1; bus_wr = 1; bus_addr = A_CAP; bus_wdata = 32'h1;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    rd_chk("R10 edge wins", A_CAP, 32'h1);
    wr(A_CAP, 32'h1);

    // R11 mask then acknowledge
    set_pins(32'h0); set_pins(32'h1);
    wr(A_SET, 32'h1);
    @(negedge clk);
    chk("R11 irq before mask", 32'(irq_out), 1);
    wr(A_CLR, 32'h1); wr(A_CAP, 32'h1);
    @(negedge clk);
    chk("R11 irq after", 32'(irq_out), 0);
    rd_chk("R11 not pending", A_CAP, 0);

    // Random phase against the model (R4..R10)
    pend_rd = 0; pend_exp = '0;
    for (int n = 0; n < 3000; n++) begin
      int r;
      @(negedge clk);
      if (pend_rd) chk("R2 random read", bus_rdata, pend_exp);
      chk("R9 random irq", 32'(irq_out), 32'(m_irq));
      pend_rd = 0;
      bus_sel = 0; bus_wr = 0;
      for (int i = 0; i < NP; i++) if ($urandom % 16 == 0) pins[i] = ~pins[i];
      r = $urandom % 10;
      if (r < 3) begin
        logic [7:0] ad;
        case ($urandom % 6)
          0: ad = A_POL; 1: ad = A_BOTH; 2: ad = A_CAP;
          3: ad = A_MODE; 4: ad = A_SET; default: ad = A_CLR;
        endcase
        bus_sel = 1; bus_wr = 1; bus_addr = ad; bus_wdata = $urandom;
      end else if (r < 7) begin
        logic [7:0] ad;
        case ($urandom % 7)
          0: ad = A_POL; 1: ad = A_BOTH; 2: ad = A_CAP; 3: ad = A_MODE;
          4: ad = A_SET; 5: ad = A_CLR; default: ad = 8'h00;
        endcase
        bus_sel = 1; bus_wr = 0; bus_addr = ad;
        pend_rd = 1; pend_exp = m_read(ad);
      end
    end
    @(negedge clk);
    if (pend_rd) chk("R2 random read", bus_rdata, pend_exp);
    bus_sel = 0; bus_wr = 0;

    done = 1;
    summary();
  end
endmodule